// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block drains a ring of transmit buffer descriptors held in system memory. Software loads the ring start address, sets the controller enable and strobes a transmit demand. The engine then reads one descriptor after another through a word-wide memory master port. It fetches the bytes of each described buffer and streams them out on a byte-wide valid/ready interface. Buffers chained without a last flag are joined into one frame. After each buffer it writes the descriptor's first word back with the ready flag cleared and pulses an event.

A descriptor occupies 8 bytes and is stored big-endian. The word at the descriptor address holds the 16-bit flags in bits 31:16 and the 16-bit buffer length in bits 15:0. The word at address +4 holds the buffer address. The walk ends at the first descriptor that is not ready, or once a parameterised number of descriptors has been handled. A frame that grows past a parameterised byte cap is cut at the cap and flagged. The engine holds back one byte, so it always knows which byte ends the frame; no frame buffer is needed.

Top module: `txbd_gather`

## Requirements
- R1: After reset, busy_o, mem_req_o, tx_valid_o and all three event outputs are low.
- R2: A demand strobe while enable_i is low has no effect: busy_o stays low and no memory request is issued.
- R3: A ring start write while idle stores base_addr_i with bits 1:0 forced to zero. The write also reloads the current descriptor pointer, so the next demand fetches its first descriptor from that aligned address.
- R4: A descriptor is two big-endian words. Word 0 holds the flags in bits 31:16 and the length in bits 15:0; word 1 holds the buffer address. In the flags, bit 15 is ready, bit 13 is wrap and bit 11 is last. A memory request holds its address and direction until mem_ack_i.
- R5: The walk stops at the first descriptor whose ready flag is clear. That descriptor is not written back, and the pointer stays on it for the next demand.
- R6: Buffer bytes leave in ascending address order at any byte alignment. The byte at the lowest address of a word is bits 31:24. Buffers are joined into one frame until a last-flagged descriptor, and tx_last_o marks only the final byte of that descriptor.
- R7: A buffer that would push the frame past MAX_FRAME bytes contributes only the bytes up to the cap, and evt_babble_o pulses for that descriptor.
- R8: Every handled descriptor has word 0 written back with bit 31 cleared and all other bits unchanged, including the original length. evt_buf_o pulses once per descriptor, and evt_frame_o also pulses for a last-flagged one.
- R9: After a descriptor with the wrap flag set, the next descriptor is at the ring start address; otherwise it is at the current address plus 8.
- R10: One demand handles at most MAX_DESC descriptors. The pointer is left on the next descriptor, so a following demand continues from there.
- R11: busy_o is high from the cycle after an accepted demand until the walk ends. A demand that arrives while busy is ignored.
- R12: If a walk ends in the middle of a frame, the last byte already gathered is sent with tx_last_o. The frame byte count restarts at zero on every demand.
- R13: While tx_valid_o is high and tx_ready_i is low, tx_data_o and tx_last_o hold their values and tx_valid_o stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Controller enable; demands are taken only while high |
| demand_i | input | 1 | Transmit demand strobe |
| base_wr_i | input | 1 | Ring start address write strobe |
| base_addr_i | input | ADDR_W | Ring start address value |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Sink accepts the byte |
| evt_buf_o | output | 1 | Pulse: one descriptor finished |
| evt_frame_o | output | 1 | Pulse: a frame was completed |
| evt_babble_o | output | 1 | Pulse: a buffer was cut at the frame cap |

## Verification
The assertions assume the memory raises mem_ack_i only while a request is pending, and returns read data in the same cycle as that acknowledge. They also assume ring start writes come only while the engine is idle. The bench memory model acknowledges only a pending request, one cycle or more after it appears. The bench writes the ring start address only after busy_o has fallen. Stalls on tx_ready_i and on the memory acknowledge follow a repeating pattern, so the hold properties are exercised at many points in the byte stream.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
   localparam int WORD_W      = 32;
   localparam int LEN_W       = 16;
   localparam int DESC_STRIDE = 8;
   localparam int FLG_READY   = 15;
   localparam int FLG_WRAP    = 13;
   localparam int FLG_LAST    = 11;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESC0,
      ST_DESC1,
      ST_FETCH,
      ST_EMIT,
      ST_BUFEND,
      ST_FLUSH,
      ST_WBACK
   } txbd_state_e;
endpackage

// File: rtl/txbd_clip.sv
module txbd_clip #(
   parameter int MAX_FRAME = 2032,
   parameter int LEN_W     = 16,
   parameter int FS_W      = 11
) (
   input  logic [LEN_W-1:0] len_i,
   input  logic [FS_W-1:0]  fsize_i,
   output logic [LEN_W-1:0] eff_o,
   output logic             over_o
);
   localparam int SUM_W = LEN_W + 1;

   logic [SUM_W-1:0] room;

   always_comb begin
      room   = SUM_W'(MAX_FRAME) - SUM_W'(fsize_i);
      over_o = ({1'b0, len_i} > room);
      eff_o  = over_o ? room[LEN_W-1:0] : len_i;
   end
endmodule

// File: rtl/txbd_lane_sel.sv
module txbd_lane_sel #(
   parameter int WORD_BYTES = 4,
   localparam int LANE_W    = $clog2(WORD_BYTES)
) (
   input  logic [8*WORD_BYTES-1:0] word_i,
   input  logic [LANE_W-1:0]       lane_i,
   output logic [7:0]              byte_o
);
   logic [7:0] lanes [WORD_BYTES];

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
      assign lanes[k] = word_i[8*(WORD_BYTES-1-k) +: 8];
   end

   assign byte_o = lanes[lane_i];
endmodule

// File: rtl/txbd_next_ptr.sv
module txbd_next_ptr #(
   parameter int ADDR_W = 32,
   parameter int STRIDE = 8
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              wrap_i,
   output logic [ADDR_W-1:0] nxt_o
);
   assign nxt_o = wrap_i ? base_i : (cur_i + ADDR_W'(STRIDE));
endmodule

// File: rtl/txbd_gather.sv
module txbd_gather
   import txbd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int MAX_FRAME = 2032,
   parameter int MAX_DESC  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              demand_i,
   input  logic              base_wr_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   output logic              busy_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [31:0]       mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [31:0]       mem_rdata_i,
   output logic [7:0]        tx_data_o,
   output logic              tx_valid_o,
   output logic              tx_last_o,
   input  logic              tx_ready_i,
   output logic              evt_buf_o,
   output logic              evt_frame_o,
   output logic              evt_babble_o
);
   localparam int FS_W = $clog2(MAX_FRAME + 1);
   localparam int DC_W = $clog2(MAX_DESC + 1);
   localparam logic [LEN_W-1:0] READY_MASK = LEN_W'(1) << FLG_READY;

   if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("txbd_gather: ADDR_W must lie in 8..32");
   end
   if (MAX_FRAME < 1 || MAX_FRAME >= (1 << LEN_W)) begin : g_bad_frame
      $error("txbd_gather: MAX_FRAME must fit the length field");
   end
   if (MAX_DESC < 1) begin : g_bad_desc
      $error("txbd_gather: MAX_DESC must be at least 1");
   end

   txbd_state_e       state_q;
   logic [ADDR_W-1:0] base_q, dptr_q, bptr_q, nxt_ptr, base_masked;
   logic [LEN_W-1:0]  flags_q, len_q, rem_q, eff_len;
   logic [31:0]       word_q;
   logic [FS_W-1:0]   fsize_q;
   logic [DC_W-1:0]   dcnt_q;
   logic [7:0]        hold_b_q, cur_byte;
   logic              hold_v_q, trunc_q, end_idle_q, over;
   logic              evt_buf_q, evt_frm_q, evt_bab_q;
   logic              emit_adv;

   assign base_masked = base_addr_i & ~ADDR_W'(3);

   txbd_clip #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W), .FS_W(FS_W)) i_clip (
      .len_i   (len_q),
      .fsize_i (fsize_q),
      .eff_o   (eff_len),
      .over_o  (over)
   );

   txbd_lane_sel #(.WORD_BYTES(WORD_W / 8)) i_lane (
      .word_i (word_q),
      .lane_i (bptr_q[1:0]),
      .byte_o (cur_byte)
   );

   txbd_next_ptr #(.ADDR_W(ADDR_W), .STRIDE(DESC_STRIDE)) i_next (
      .cur_i  (dptr_q),
      .base_i (base_q),
      .wrap_i (flags_q[FLG_WRAP]),
      .nxt_o  (nxt_ptr)
   );

   assign emit_adv = !hold_v_q || tx_ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         dptr_q     <= '0;
         bptr_q     <= '0;
         flags_q    <= '0;
         len_q      <= '0;
         rem_q      <= '0;
         word_q     <= '0;
         fsize_q    <= '0;
         dcnt_q     <= '0;
         hold_b_q   <= '0;
         hold_v_q   <= 1'b0;
         trunc_q    <= 1'b0;
         end_idle_q <= 1'b0;
         evt_buf_q  <= 1'b0;
         evt_frm_q  <= 1'b0;
         evt_bab_q  <= 1'b0;
      end else begin
         evt_buf_q <= 1'b0;
         evt_frm_q <= 1'b0;
         evt_bab_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (base_wr_i) begin
                  base_q <= base_masked;
                  dptr_q <= base_masked;
               end
               if (demand_i && enable_i) begin
                  fsize_q <= '0;
                  dcnt_q  <= '0;
                  state_q <= ST_DESC0;
               end
            end
            ST_DESC0: begin
               if (mem_ack_i) begin
                  if (!mem_rdata_i[16 + FLG_READY]) begin
                     if (hold_v_q) begin
                        end_idle_q <= 1'b1;
                        state_q    <= ST_FLUSH;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     flags_q <= mem_rdata_i[31:16];
                     len_q   <= mem_rdata_i[15:0];
                     state_q <= ST_DESC1;
                  end
               end
            end
            ST_DESC1: begin
               if (mem_ack_i) begin
                  bptr_q  <= mem_rdata_i[ADDR_W-1:0];
                  rem_q   <= eff_len;
                  trunc_q <= over;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (rem_q == '0) begin
                  state_q <= ST_BUFEND;
               end else if (mem_ack_i) begin
                  word_q  <= mem_rdata_i;
                  state_q <= ST_EMIT;
               end
            end
            ST_EMIT: begin
               if (emit_adv) begin
                  hold_b_q <= cur_byte;
                  hold_v_q <= 1'b1;
                  bptr_q   <= bptr_q + ADDR_W'(1);
                  rem_q    <= rem_q - LEN_W'(1);
                  fsize_q  <= fsize_q + FS_W'(1);
                  if (rem_q == LEN_W'(1)) begin
                     state_q <= ST_BUFEND;
                  end else if (bptr_q[1:0] == 2'b11) begin
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_BUFEND: begin
               if (flags_q[FLG_LAST] && hold_v_q) begin
                  end_idle_q <= 1'b0;
                  state_q    <= ST_FLUSH;
               end else begin
                  state_q <= ST_WBACK;
               end
            end
            ST_FLUSH: begin
               if (tx_ready_i) begin
                  hold_v_q   <= 1'b0;
                  end_idle_q <= 1'b0;
                  state_q    <= end_idle_q ? ST_IDLE : ST_WBACK;
               end
            end
            ST_WBACK: begin
               if (mem_ack_i) begin
                  evt_buf_q <= 1'b1;
                  evt_frm_q <= flags_q[FLG_LAST];
                  evt_bab_q <= trunc_q;
                  dptr_q    <= nxt_ptr;
                  dcnt_q    <= dcnt_q + DC_W'(1);
                  if (flags_q[FLG_LAST]) begin
                     fsize_q <= '0;
                  end
                  if (dcnt_q == DC_W'(MAX_DESC - 1)) begin
                     if (hold_v_q) begin
                        end_idle_q <= 1'b1;
                        state_q    <= ST_FLUSH;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     state_q <= ST_DESC0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = dptr_q;
      mem_wdata_o = {flags_q & ~READY_MASK, len_q};
      unique case (state_q)
         ST_DESC0: mem_req_o = 1'b1;
         ST_DESC1: begin
            mem_req_o  = 1'b1;
            mem_addr_o = dptr_q + ADDR_W'(4);
         end
         ST_FETCH: begin
            mem_req_o  = (rem_q != '0);
            mem_addr_o = {bptr_q[ADDR_W-1:2], 2'b00};
         end
         ST_WBACK: begin
            mem_req_o = 1'b1;
            mem_we_o  = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy_o       = (state_q != ST_IDLE);
   assign tx_data_o    = hold_b_q;
   assign tx_valid_o   = (state_q == ST_FLUSH) || ((state_q == ST_EMIT) && hold_v_q);
   assign tx_last_o    = (state_q == ST_FLUSH);
   assign evt_buf_o    = evt_buf_q;
   assign evt_frame_o  = evt_frm_q;
   assign evt_babble_o = evt_bab_q;

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)); // R13
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R4
   AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(enable_i && demand_i)); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !mem_req_o && !tx_valid_o); // R11
   AST_WB_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_req_o && mem_we_o |-> !mem_wdata_o[31]); // R8
   AST_EVT_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n) evt_buf_o |-> $past(mem_req_o && mem_we_o && mem_ack_i)); // R8
   AST_FRAME_EVT_PAIR: assert property (@(posedge clk) disable iff (!rst_n) evt_frame_o |-> evt_buf_o); // R8
   AST_FRAME_CAP: assert property (@(posedge clk) disable iff (!rst_n) fsize_q <= FS_W'(MAX_FRAME)); // R7
   AST_DESC_CAP: assert property (@(posedge clk) disable iff (!rst_n) dcnt_q <= DC_W'(MAX_DESC)); // R10
endmodule

// File: tb/test_txbd_gather.sv
`timescale 1ns/1ps
module test_txbd_gather;
   localparam int AW     = 32;
   localparam int CAP    = 40;
   localparam int DCAP   = 6;
   localparam int MEMSZ  = 4096;
   localparam logic [31:0] VEC [6] = '{
      32'h0400_0001, 32'h0401_0003, 32'h0402_0004,
      32'h0403_0009, 32'h0410_0010, 32'h0405_0001
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, demand = 1'b0, base_wr = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic busy, mem_req, mem_we, mem_ack, tx_valid, tx_last, tx_ready;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic [7:0] tx_data;
   logic evt_buf, evt_frame, evt_babble;

   logic [7:0] mem [MEMSZ];
   logic [7:0] cap_d [256];
   logic       cap_l [256];
   int n_cap, n_evb, n_evf, n_bab, n_req;
   int n_chk = 0, n_bad = 0;
   logic stall = 1'b0;
   logic [15:0] cyc = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   txbd_gather #(.ADDR_W(AW), .MAX_FRAME(CAP), .MAX_DESC(DCAP)) i_txbd_gather (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .demand_i(demand),
      .base_wr_i(base_wr), .base_addr_i(base_addr), .busy_o(busy),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
      .tx_ready_i(tx_ready), .evt_buf_o(evt_buf), .evt_frame_o(evt_frame),
      .evt_babble_o(evt_babble)
   );

   function automatic logic [31:0] rdword(input logic [AW-1:0] a);
      int b;
      b = int'(a[11:0]) & 12'hFFC;
      return {mem[b], mem[b+1], mem[b+2], mem[b+3]};
   endfunction

   always @(posedge clk) begin
      cyc <= cyc + 16'd1;
      tx_ready <= stall ? (cyc[1:0] != 2'b01) : 1'b1;
      if (!rst_n) begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
      end else begin
         if (mem_req && mem_ack && mem_we) begin
            for (int k = 0; k < 4; k++)
               mem[(int'(mem_addr[11:0]) & 12'hFFC) + k] = mem_wdata[8*(3-k) +: 8];
         end
         mem_ack <= mem_req && !mem_ack && (!stall || cyc[0]);
         mem_rdata <= rdword(mem_addr);
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_valid && tx_ready) begin
            cap_d[n_cap & 255] = tx_data;
            cap_l[n_cap & 255] = tx_last;
            n_cap++;
         end
         if (evt_buf) n_evb++;
         if (evt_frame) n_evf++;
         if (evt_babble) n_bab++;
         if (mem_req) n_req++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_mon();
      n_cap = 0; n_evb = 0; n_evf = 0; n_bab = 0; n_req = 0;
   endtask

   task automatic put_desc(input int a, input logic [15:0] fl, input logic [15:0] ln, input int b);
      mem[a] = fl[15:8]; mem[a+1] = fl[7:0];
      mem[a+2] = ln[15:8]; mem[a+3] = ln[7:0];
      mem[a+4] = 8'(b >> 24); mem[a+5] = 8'(b >> 16);
      mem[a+6] = 8'(b >> 8);  mem[a+7] = 8'(b);
   endtask

   function automatic int rd16(input int a);
      return int'({mem[a], mem[a+1]});
   endfunction

   task automatic set_base(input int a);
      @(negedge clk); base_addr = AW'(a); base_wr = 1'b1;
      @(negedge clk); base_wr = 1'b0;
   endtask

   task automatic kick(output logic busy_seen);
      @(negedge clk); demand = 1'b1;
      @(negedge clk); demand = 1'b0; busy_seen = busy;
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 5000) begin @(negedge clk); t++; end
      if (t >= 5000) chk(1'b0, "walk timeout", t, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic check_bytes(input int idx0, input int a, input int n, input string tag);
      int bad_at = -1;
      for (int i = 0; i < n; i++)
         if (bad_at < 0 && cap_d[(idx0 + i) & 255] !== mem[a + i]) bad_at = i;
      chk(bad_at < 0, tag, (bad_at < 0) ? 0 : int'(cap_d[(idx0 + bad_at) & 255]),
          (bad_at < 0) ? 0 : int'(mem[a + bad_at]));
   endtask

   task automatic check_lasts(input int pos_a, input int pos_b, input string tag);
      int cnt = 0;
      bit ok = 1'b1;
      for (int i = 0; i < n_cap && i < 256; i++) begin
         if (cap_l[i]) cnt++;
         if (cap_l[i] !== ((i == pos_a) || (i == pos_b))) ok = 1'b0;
      end
      chk(ok, tag, cnt, (pos_b >= 0) ? 2 : ((pos_a >= 0) ? 1 : 0));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic bs;
      for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(i * 7 + 3);
      clear_mon();
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(!busy && !mem_req && !tx_valid && !evt_buf && !evt_frame && !evt_babble,
          "R1 reset outputs", int'({busy, mem_req, tx_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !tx_valid, "R1 idle after reset", int'(busy), 0);

      // R2: demand while disabled
      enable = 1'b0;
      put_desc(32'h080, 16'hA800, 16'd4, 32'h400);
      set_base(32'h080);
      clear_mon();
      kick(bs);
      repeat (10) @(negedge clk);
      chk(!bs && !busy, "R2 busy stays low while disabled", int'(bs), 0);
      chk(n_req == 0, "R2 no memory request while disabled", n_req, 0);
      chk(rd16(32'h080) == 16'hA800, "R2 descriptor untouched", rd16(32'h080), 16'hA800);
      enable = 1'b1;

      // R4 R6 R8: single-buffer frames at varied alignment, walked from the table
      for (int v = 0; v < 6; v++) begin
         int ba, ln;
         ba = int'(VEC[v][31:16]);
         ln = int'(VEC[v][15:0]);
         put_desc(32'h080, 16'hA800, 16'(ln), ba);
         set_base(32'h080);
         clear_mon();
         kick(bs);
         wait_idle();
         chk(n_cap == ln, "R6 vector byte count", n_cap, ln);
         check_bytes(0, ba, ln, "R6 vector byte order");
         check_lasts(ln - 1, -1, "R6 vector last marker");
         chk(n_evb == 1 && n_evf == 1, "R8 vector events", n_evb * 10 + n_evf, 11);
         chk(rd16(32'h080) == 16'h2800 && rd16(32'h082) == ln, "R4 vector write-back word",
             rd16(32'h080), 16'h2800);
      end

      // R3: ring start low bits dropped
      put_desc(32'h200, 16'hA800, 16'd2, 32'h500);
      set_base(32'h203);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_cap == 2, "R3 fetch from aligned start", n_cap, 2);
      check_bytes(0, 32'h500, 2, "R3 data from aligned start");
      chk(rd16(32'h200) == 16'h2800, "R3 aligned descriptor written back", rd16(32'h200), 16'h2800);

      // R6 R8 R9 R11: two-buffer gather with wrap
      put_desc(32'h240, 16'h8000, 16'd3, 32'h601);
      put_desc(32'h248, 16'hA800, 16'd5, 32'h613);
      put_desc(32'h250, 16'h8800, 16'd1, 32'h650);
      set_base(32'h240);
      clear_mon();
      kick(bs);
      chk(bs, "R11 busy after accepted demand", int'(bs), 1);
      wait_idle();
      chk(n_cap == 8, "R6 gather byte count", n_cap, 8);
      check_bytes(0, 32'h601, 3, "R6 gather first buffer");
      check_bytes(3, 32'h613, 5, "R6 gather second buffer");
      check_lasts(7, -1, "R6 last only at frame end");
      chk(n_evb == 2 && n_evf == 1, "R8 gather events", n_evb * 10 + n_evf, 21);
      chk(rd16(32'h240) == 16'h0000 && rd16(32'h242) == 3, "R8 write-back keeps length",
          rd16(32'h242), 3);
      chk(rd16(32'h250) == 16'h8800, "R9 wrap skips following slot", rd16(32'h250), 16'h8800);
      put_desc(32'h240, 16'h8800, 16'd1, 32'h620);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_cap == 1 && cap_d[0] == mem[32'h620], "R9 walk resumes at ring start",
          n_cap, 1);

      // R5: first descriptor not ready
      put_desc(32'h2C0, 16'h0800, 16'd4, 32'h400);
      set_base(32'h2C0);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_cap == 0 && n_evb == 0, "R5 nothing sent when not ready", n_cap + n_evb, 0);
      chk(rd16(32'h2C0) == 16'h0800, "R5 not-ready descriptor not written", rd16(32'h2C0), 16'h0800);

      // R7 R13: frame cap with sink and memory stalls
      stall = 1'b1;
      put_desc(32'h300, 16'h8000, 16'd30, 32'h700);
      put_desc(32'h308, 16'h8800, 16'd20, 32'h740);
      put_desc(32'h310, 16'hA800, 16'd5, 32'h780);
      set_base(32'h300);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_cap == 45, "R7 capped frame plus next frame", n_cap, 45);
      check_bytes(0, 32'h700, 30, "R13 bytes intact under stalls");
      check_bytes(30, 32'h740, 10, "R7 cut buffer bytes");
      check_bytes(40, 32'h780, 5, "R7 following frame bytes");
      check_lasts(39, 44, "R7 last markers");
      chk(n_bab == 1, "R7 babble pulse count", n_bab, 1);
      chk(rd16(32'h30A) == 20, "R8 cut descriptor length unchanged", rd16(32'h30A), 20);

      // R10 R11: descriptor cap and ignored demand while busy
      for (int i = 0; i < 8; i++) put_desc(32'h100 + 8 * i, 16'h8800, 16'd1, 32'h480 + i);
      put_desc(32'h140, 16'h0000, 16'd1, 32'h490);
      set_base(32'h100);
      clear_mon();
      kick(bs);
      repeat (6) @(negedge clk);
      demand = 1'b1;
      @(negedge clk);
      demand = 1'b0;
      wait_idle();
      repeat (5) @(negedge clk);
      chk(!busy, "R11 demand while busy ignored", int'(busy), 0);
      chk(n_evb == DCAP && n_cap == DCAP, "R10 descriptor cap", n_evb, DCAP);
      chk(rd16(32'h130) == 16'h8800, "R10 descriptor past cap still ready", rd16(32'h130), 16'h8800);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_evb == 2 && n_cap == 2 && cap_d[0] == mem[32'h486], "R10 continue after cap",
          n_evb, 2);
      stall = 1'b0;

      // R12: unfinished frame closed at walk end, count restarts
      put_desc(32'h340, 16'h8000, 16'd30, 32'h700);
      put_desc(32'h348, 16'h0000, 16'd20, 32'h740);
      set_base(32'h340);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_cap == 30 && n_evf == 0, "R12 partial frame bytes", n_cap, 30);
      check_lasts(29, -1, "R12 partial frame closed");
      put_desc(32'h348, 16'hA800, 16'd20, 32'h740);
      clear_mon();
      kick(bs);
      wait_idle();
      chk(n_cap == 20 && n_bab == 0, "R12 frame count restarted", n_cap * 10 + n_bab, 200);
      check_lasts(19, -1, "R12 new frame last");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule